// File: doc/BRIEF.md
# Field-Aligned Suspend Gate for Video DMA Events

This block stands between the field timing logic of a video port and the DMA event request lines that feed the transfer engine. A debug halt request can freeze event traffic, but never in the middle of a field. The freeze takes effect on the next field boundary. When the request goes away, traffic comes back only on a later boundary that opens a field of the same parity as the one that was skipped. The DMA pointers then line up with the picture where they stopped. The block gates only events. The timing counters and sync logic that drive the field strobe are outside it and never stop, so the port stays locked to external equipment throughout.

A small 32-bit control word sets the behaviour. A run-through bit makes the port ignore debug halts, and it is set after reset. A port-enable bit must be set before any event can pass. A read-only status bit always reads zero. A separate block input gates events at once, cycle for cycle, and it does not touch the deferred halt sequencing. Clearing it does not rewind any DMA state; that is left to software. The `halted` output shows when the deferred halt is actually in force.

Top module: `vsusp_gate`

## Requirements
- R1: After synchronous reset the control word reads 0x0000_0001 (run-through set, port-enable clear), `evt_out` is all zero and `halted` is 0.
- R2: A write to address `CTRL_ADDR` (default 0) updates run-through from data bit 0 and port-enable from data bit 2. Bit 1 and bits 31:3 always read 0. A read at any other address returns 0, and writes to other addresses change nothing. Read data appears one cycle after `rd_addr`.
- R3: While run-through is 1, `dbg_halt` has no effect: `halted` stays 0 and events keep passing.
- R4: With run-through 0 and `dbg_halt` held, `halted` rises only in the cycle after a `fld_strobe` that arrives at least one cycle after the request was first seen. Events keep passing until then, and `evt_out` is zero in every cycle where `halted` is 1.
- R5: If `dbg_halt` drops before any boundary strobe reaches the pending halt, the port returns to normal running and `halted` never rises.
- R6: Once halted, removing the request keeps `halted` at 1 until a `fld_strobe` whose `fld_id` equals the `fld_id` of the strobe that started the halt. Strobes with the other ID are ignored. A strobe in the same cycle as the release is ignored. Raising the request again before the matching strobe keeps the port halted.
- R7: While port-enable is 0, `evt_out` is forced to 0 in the following cycle whatever the halt state.
- R8: `blk_gate` high in a cycle forces `evt_out` to 0 in the next cycle and does not alter the halt sequencing.
- R9: When no gate applies, each bit of `evt_out` equals the matching bit of `evt_in` from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, single cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug halt request |
| blk_gate | input | 1 | Immediate event block |
| fld_strobe | input | 1 | One-cycle field boundary pulse |
| fld_id | input | 1 | ID of the field that starts at the strobe |
| evt_in | input | NEV | DMA event requests from the port |
| evt_out | output | NEV | Gated, registered DMA event requests |
| halted | output | 1 | Deferred halt in force |

## Verification
The assertions assume that `fld_strobe` is a clean single-cycle pulse that is sampled at the clock, and that `fld_id` is only meaningful in a strobe cycle. They also assume that `rst` is held for at least one edge before any check relies on the reset state. The stimulus drives every input at the falling edge, and it spaces strobes many cycles apart with a random ID, so both matching and non-matching boundaries occur. Debug requests, block pulses and control writes are laid over those strobes with random timing, including a release that lands on a strobe cycle and a request withdrawn before any boundary.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  localparam int unsigned CTRL_DW   = 32;
  localparam int unsigned FREE_BIT  = 0;
  localparam int unsigned SOFT_BIT  = 1;
  localparam int unsigned PEREN_BIT = 2;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HPEND  = 2'd1,
    ST_HALTED = 2'd2,
    ST_RPEND  = 2'd3
  } vsg_state_e;

  function automatic logic state_gated(input vsg_state_e s);
    return (s == ST_HALTED) || (s == ST_RPEND);
  endfunction

endpackage

// File: rtl/vsg_ctrl_reg.sv
module vsg_ctrl_reg
  import vsg_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CTRL_DW-1:0] wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [CTRL_DW-1:0] rd_data,
  output logic               free_q,
  output logic               peren_q
);

  localparam logic [AW-1:0] SEL = AW'(CTRL_ADDR);

  logic               hit_wr;
  logic               hit_rd;
  logic [CTRL_DW-1:0] word;
  logic               unused_wr_bits;

  assign hit_wr = wr_en && (wr_addr == SEL);
  assign hit_rd = (rd_addr == SEL);
  assign unused_wr_bits = ^{wr_data[CTRL_DW-1:PEREN_BIT+1], wr_data[SOFT_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q  <= 1'b1;
      peren_q <= 1'b0;
    end else if (hit_wr) begin
      free_q  <= wr_data[FREE_BIT];
      peren_q <= wr_data[PEREN_BIT];
    end
  end

  always_comb begin
    word            = '0;
    word[FREE_BIT]  = free_q;
    word[SOFT_BIT]  = 1'b0;
    word[PEREN_BIT] = peren_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= hit_rd ? word : '0;
    end
  end

endmodule

// File: rtl/vsg_susp_fsm.sv
module vsg_susp_fsm
  import vsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic susp_ok,
  input  logic fld_strobe,
  input  logic fld_id,
  output logic halt_nxt,
  output logic halted
);

  vsg_state_e st_q;
  vsg_state_e st_d;
  logic       hid_q;
  logic       capture;

  always_comb begin
    st_d    = st_q;
    capture = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (susp_ok) st_d = ST_HPEND;
      end
      ST_HPEND: begin
        if (!susp_ok) begin
          st_d = ST_RUN;
        end else if (fld_strobe) begin
          st_d    = ST_HALTED;
          capture = 1'b1;
        end
      end
      ST_HALTED: begin
        if (!susp_ok) st_d = ST_RPEND;
      end
      ST_RPEND: begin
        if (susp_ok) begin
          st_d = ST_HALTED;
        end else if (fld_strobe && (fld_id == hid_q)) begin
          st_d = ST_RUN;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  assign halt_nxt = state_gated(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      hid_q  <= 1'b0;
      halted <= 1'b0;
    end else begin
      st_q   <= st_d;
      halted <= halt_nxt;
      if (capture) hid_q <= fld_id;
    end
  end

endmodule

// File: rtl/vsg_evt_gate.sv
module vsg_evt_gate #(
  parameter int unsigned NEV = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt_in,
  input  logic           pass,
  output logic [NEV-1:0] evt_out
);

  for (genvar g = 0; g < NEV; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        evt_out[g] <= 1'b0;
      end else begin
        evt_out[g] <= evt_in[g] & pass;
      end
    end
  end

endmodule

// File: rtl/vsusp_gate.sv
module vsusp_gate
  import vsg_pkg::*;
#(
  parameter int unsigned NEV       = 4,
  parameter int unsigned AW        = 4,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CTRL_DW-1:0] wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [CTRL_DW-1:0] rd_data,
  input  logic               dbg_halt,
  input  logic               blk_gate,
  input  logic               fld_strobe,
  input  logic               fld_id,
  input  logic [NEV-1:0]     evt_in,
  output logic [NEV-1:0]     evt_out,
  output logic               halted
);

  logic free_q;
  logic peren_q;
  logic susp_ok;
  logic halt_nxt;
  logic pass;

  vsg_ctrl_reg #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .free_q  (free_q),
    .peren_q (peren_q)
  );

  assign susp_ok = dbg_halt && !free_q;

  vsg_susp_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .susp_ok    (susp_ok),
    .fld_strobe (fld_strobe),
    .fld_id     (fld_id),
    .halt_nxt   (halt_nxt),
    .halted     (halted)
  );

  assign pass = peren_q && !blk_gate && !halt_nxt;

  vsg_evt_gate #(.NEV(NEV)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .evt_in  (evt_in),
    .pass    (pass),
    .evt_out (evt_out)
  );

endmodule

// File: rtl/vsg_gate_chk.sv
module vsg_gate_chk #(
  parameter int unsigned NEV = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           dbg_halt,
  input logic           blk_gate,
  input logic           fld_strobe,
  input logic [NEV-1:0] evt_out,
  input logic           halted,
  input logic           free_q,
  input logic           peren_q
);

  // R1: reset clears outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (evt_out == '0) && !halted);

  // R3: run-through keeps the port from halting
  a_r3_free_no_halt: assert property (@(posedge clk) disable iff (rst)
    (!halted && free_q) |=> !halted);

  // R4: halt only takes effect after a boundary strobe
  a_r4_halt_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(fld_strobe));

  // R4: nothing leaves the port while halted
  a_r4_halted_silent: assert property (@(posedge clk) disable iff (rst)
    halted |-> (evt_out == '0));

  // R6: resume only on a boundary with the request gone
  a_r6_resume_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> ($past(fld_strobe) && !($past(dbg_halt) && !$past(free_q))));

  // R7: port-enable low blocks events
  a_r7_peren_gate: assert property (@(posedge clk) disable iff (rst)
    !peren_q |=> (evt_out == '0));

  // R8: immediate block
  a_r8_block_gate: assert property (@(posedge clk) disable iff (rst)
    blk_gate |=> (evt_out == '0));

endmodule

bind vsusp_gate vsg_gate_chk #(.NEV(NEV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dbg_halt   (dbg_halt),
  .blk_gate   (blk_gate),
  .fld_strobe (fld_strobe),
  .evt_out    (evt_out),
  .halted     (halted),
  .free_q     (free_q),
  .peren_q    (peren_q)
);

// File: tb/sim_vsusp_gate.sv
`timescale 1ns/1ps
module sim_vsusp_gate;

  localparam int NEV = 4;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [31:0]    rd_data;
  logic           dbg_halt = 1'b0;
  logic           blk_gate = 1'b0;
  logic           fld_strobe = 1'b0;
  logic           fld_id = 1'b0;
  logic [NEV-1:0] evt_in = '0;
  logic [NEV-1:0] evt_out;
  logic           halted;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  vsusp_gate #(.NEV(NEV), .AW(AW), .CTRL_ADDR(0)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt), .blk_gate(blk_gate),
    .fld_strobe(fld_strobe), .fld_id(fld_id), .evt_in(evt_in), .evt_out(evt_out),
    .halted(halted)
  );

  // behavioural reference: mode 0 running, 1 waiting to halt, 2 halted, 3 waiting to resume
  int          m_mode = 0;
  bit          m_free = 1, m_peren = 0, m_hid = 0, m_halt = 0;
  logic [31:0] m_rd = 0;
  logic [NEV-1:0] m_evt = 0;

  always @(posedge clk) begin
    bit req;
    int nxt;
    if (rst) begin
      m_mode = 0; m_free = 1; m_peren = 0; m_hid = 0; m_halt = 0; m_rd = 0; m_evt = 0;
    end else begin
      req = dbg_halt && !m_free;
      nxt = m_mode;
      if (m_mode == 0 && req) nxt = 1;
      else if (m_mode == 1) begin
        if (!req) nxt = 0;
        else if (fld_strobe) begin nxt = 2; m_hid = fld_id; end
      end else if (m_mode == 2 && !req) nxt = 3;
      else if (m_mode == 3) begin
        if (req) nxt = 2;
        else if (fld_strobe && fld_id == m_hid) nxt = 0;
      end
      m_evt  = (m_peren && !blk_gate && nxt < 2) ? evt_in : '0;
      m_rd   = (rd_addr == 0) ? {29'd0, m_peren, 1'b0, m_free} : 32'd0;
      if (wr_en && wr_addr == 0) begin m_free = wr_data[0]; m_peren = wr_data[2]; end
      m_mode = nxt;
      m_halt = (nxt >= 2);
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_tests++;
      if (evt_out !== m_evt || halted !== m_halt || rd_data !== m_rd) begin
        n_fail++;
        $display("FAIL R4/R6/R9 model: evt=%h halted=%b rd=%h expected evt=%h halted=%b rd=%h",
                 evt_out, halted, rd_data, m_evt, m_halt, m_rd);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    tick();
    d = rd_data;
    rd_addr = 0;
  endtask

  task automatic strobe(bit id);
    fld_strobe = 1; fld_id = id;
    tick();
    fld_strobe = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 evt_out", 32'(evt_out), 0);
    chk("R1 halted", 32'(halted), 0);
    rst = 0;
    rd(0, v); chk("R1 ctrl word", v, 32'h1);

    // R2: only writable bits stick; other addresses inert
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 ctrl read", v, 32'h5);
    wr(3, 32'h0);
    rd(3, v); chk("R2 other addr read", v, 32'h0);
    rd(0, v); chk("R2 ctrl kept", v, 32'h5);

    // R3: run-through set, halts ignored; R9: passthrough
    dbg_halt = 1; evt_in = 4'hA;
    tick();
    strobe(1);
    tick();
    chk("R3 halted", 32'(halted), 0);
    chk("R9 evt passthrough", 32'(evt_out), 32'hA);
    dbg_halt = 0;

    // R4: clear run-through, request, wait for boundary
    wr(0, 32'h4);
    dbg_halt = 1; evt_in = 4'h5;
    repeat (4) tick();
    chk("R4 pending not halted", 32'(halted), 0);
    chk("R4 events still pass", 32'(evt_out), 32'h5);
    strobe(1);
    chk("R4 halted after boundary", 32'(halted), 1);
    chk("R4 silent while halted", 32'(evt_out), 0);

    // R6: release, wrong-ID boundary ignored, matching one resumes
    dbg_halt = 0;
    tick();
    chk("R6 still halted after release", 32'(halted), 1);
    strobe(0);
    chk("R6 wrong id ignored", 32'(halted), 1);
    dbg_halt = 1; tick(); dbg_halt = 0; tick();
    chk("R6 re-request keeps halt", 32'(halted), 1);
    strobe(1);
    chk("R6 resumed", 32'(halted), 0);
    chk("R6 events back", 32'(evt_out), 32'h5);

    // R5: withdrawn request
    dbg_halt = 1; tick(); tick(); dbg_halt = 0; tick();
    strobe(0); strobe(1);
    chk("R5 never halted", 32'(halted), 0);

    // R8: block gate is immediate and leaves sequencing alone
    blk_gate = 1; evt_in = 4'hF;
    tick();
    chk("R8 blocked", 32'(evt_out), 0);
    blk_gate = 0;
    tick();
    chk("R8 unblocked", 32'(evt_out), 32'hF);
    chk("R8 no halt", 32'(halted), 0);

    // R7: port-enable clear forces zero
    wr(0, 32'h0);
    tick();
    chk("R7 peren off", 32'(evt_out), 0);
    wr(0, 32'h4);

    // randomized run against the model
    for (int c = 0; c < 4000; c++) begin
      evt_in     = NEV'($urandom);
      fld_strobe = (c % 17 == 16);
      fld_id     = 1'($urandom);
      if ($urandom_range(0, 39) == 0) dbg_halt = ~dbg_halt;
      blk_gate   = ($urandom_range(0, 29) == 0);
      rd_addr    = ($urandom_range(0, 3) == 0) ? AW'($urandom) : '0;
      wr_en      = ($urandom_range(0, 199) == 0);
      wr_addr    = ($urandom_range(0, 1) == 0) ? '0 : AW'($urandom);
      wr_data    = $urandom | 32'h4;
      if ($urandom_range(0, 3) == 0) wr_data[0] = 1'b1; else wr_data[0] = 1'b0;
      tick();
    end
    wr_en = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    done = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule